// File: doc/BRIEF.md
# Two-Bank Maskable Interrupt Controller

This block collects 64 level-sensitive interrupt requests from on-chip peripherals and presents them to a processor core. The requests are split into two banks of 32. Each bank has its own enable (mask) register and its own steering register. Both are reached over a small word-addressed register bus. An enabled, pending source drives one of two request lines. It goes to the normal request line when its steering bit is 0 and to the fast request line when its steering bit is 1.

Each request input passes through a two-flop synchronizer first. After that, the block shows the raw levels, and separately the enabled-and-steered levels, as read-only registers. A control bit selects which pending sources end an idle state: either any pending source, or only enabled ones. A one-bit wake-enable register lets the real-time-clock alarm source (a fixed source index, set by parameter) raise a system wake signal. Clearing a request is the peripheral's job: the block stores no request state beyond the synchronizer.

Register map (word address on `reg_addr`). Bits 3..1 select the register kind and bit 0 selects the bank:

| Address | Register |
|---|---|
| 0x0 / 0x1 | enable (mask), bank 0 / bank 1 |
| 0x2 / 0x3 | steering, bank 0 / bank 1 |
| 0x4 / 0x5 | raw pending, bank 0 / bank 1 |
| 0x6 / 0x7 | normal-line pending, bank 0 / bank 1 |
| 0x8 / 0x9 | fast-line pending, bank 0 / bank 1 |
| 0xA | idle qualifier, bit 0 |
| 0xB | alarm wake enable, bit 0 |

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, the enable, steering, idle-qualifier and wake-enable registers all read 0. With every source high, `irq_o`, `fiq_o` and `sys_wake_o` are 0.
- R2: The raw pending registers (0x4 for sources 0..31, 0x5 for sources 32..63, source k of a bank at bit k) show each input level two clock edges after it is applied. A pending bit falls two edges after its input falls.
- R3: `irq_o` is 1 exactly when some source in either bank is pending, enabled (mask bit 1) and steered to the normal line (steering bit 0).
- R4: `fiq_o` is 1 exactly when some source in either bank is pending, enabled and steered to the fast line (steering bit 1).
- R5: Addresses 0x6/0x7 read pending & mask & ~steer for bank 0/1. Addresses 0x8/0x9 read pending & mask & steer for bank 0/1.
- R6: When bit 0 of register 0xA is 1, `idle_wake_o` is the OR of pending & mask over all 64 sources. When it is 0, `idle_wake_o` is the OR of all pending bits.
- R7: `sys_wake_o` is 1 exactly when bit 0 of register 0xB is 1 and source 63 (the alarm source, bank 1 bit 31) is pending. The mask and steering registers have no effect on it.
- R8: A write to 0x0..0x3 stores the full 32-bit word and reads back unchanged. Registers 0xA and 0xB store only bit 0, and their other bits read 0. Writes to read-only or unmapped addresses change no register. Addresses 0xC..0xF read 0.
- R9: The banks are independent. A write to one bank's mask or steering register leaves the other bank's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Level-sensitive request inputs, source k at bit k |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |
| idle_wake_o | output | 1 | Idle exit request |
| sys_wake_o | output | 1 | Alarm system wake request |

## Verification
A corrupted enable or steering bit shows at once on `irq_o` or `fiq_o` when its source is pending. It also shows in the same cycle on the masked pending readout of its own bank. A one-hot sweep over all 64 sources, with alternating steering, therefore exposes any single bad bit or swapped bank within the two-edge synchronizer delay. A synchronizer that is missing a stage, or has a stage too many, shows as a raw pending bit that changes one edge early or late. A wrong idle qualifier or a wrong wake-enable bit shows directly on `idle_wake_o` or `sys_wake_o` once masked-only or alarm-only stimulus is applied.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int NUM_BANKS = 2;
  localparam int ADDR_W    = 4;

  typedef enum logic [2:0] {
    K_MASK  = 3'd0,
    K_STEER = 3'd1,
    K_RAW   = 3'd2,
    K_IRQP  = 3'd3,
    K_FIQP  = 3'd4,
    K_CTRL  = 3'd5
  } reg_kind_e;
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '0;
      stg2_q <= '0;
    end else begin
      stg1_q <= d_i;
      stg2_q <= stg1_q;
    end
  end

  assign q_o = stg2_q;

  // Counts edges since reset release, saturating at 2 (for the check below only)
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
  end

  // R2: output equals the input as sampled two edges earlier
  a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/dbi_bank.sv
module dbi_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend_i,
  input  logic         mask_we,
  input  logic         steer_we,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] steer_o,
  output logic [W-1:0] irq_pend_o,
  output logic [W-1:0] fiq_pend_o
);
  logic [W-1:0] mask_q, mask_d, steer_q, steer_d;

  always_comb begin
    mask_d  = mask_q;
    steer_d = steer_q;
    if (mask_we)  mask_d  = wdata_i;
    if (steer_we) steer_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      steer_q <= '0;
    end else begin
      mask_q  <= mask_d;
      steer_q <= steer_d;
    end
  end

  assign mask_o     = mask_q;
  assign steer_o    = steer_q;
  assign irq_pend_o = pend_i & mask_q & ~steer_q;
  assign fiq_pend_o = pend_i & mask_q &  steer_q;

  // R8: a mask write lands intact on the next edge
  a_r8_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_o == $past(wdata_i)));
  // R9: without a write strobe the steering register holds
  a_r9_steer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !steer_we |=> $stable(steer_o));
  // R5: a source never shows on both lines at once
  a_r5_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_o & fiq_pend_o) == '0);
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import dbi_pkg::*;
#(
  parameter int BANK_W  = 32,
  parameter int RTC_SRC = 63
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0]   src_i,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [BANK_W-1:0]             reg_wdata,
  output logic [BANK_W-1:0]             reg_rdata,
  output logic                          irq_o,
  output logic                          fiq_o,
  output logic                          idle_wake_o,
  output logic                          sys_wake_o
);
  localparam int NUM_SRC = NUM_BANKS * BANK_W;

  logic [NUM_SRC-1:0] pend_flat;
  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_a, steer_a, irqp_a, fiqp_a, pend_a;

  reg_kind_e kind;
  logic      bsel;
  assign kind = reg_kind_e'(reg_addr[ADDR_W-1:1]);
  assign bsel = reg_addr[0];

  dbi_sync #(.W(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(pend_flat)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign pend_a[b] = pend_flat[b*BANK_W +: BANK_W];
    dbi_bank #(.W(BANK_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend_i     (pend_a[b]),
      .mask_we    (reg_we && kind == K_MASK  && bsel == b[0]),
      .steer_we   (reg_we && kind == K_STEER && bsel == b[0]),
      .wdata_i    (reg_wdata),
      .mask_o     (mask_a[b]),
      .steer_o    (steer_a[b]),
      .irq_pend_o (irqp_a[b]),
      .fiq_pend_o (fiqp_a[b])
    );
  end

  // Idle qualifier and alarm wake enable
  logic idle_qual_q, idle_qual_d, wake_en_q, wake_en_d;
  always_comb begin
    idle_qual_d = idle_qual_q;
    wake_en_d   = wake_en_q;
    if (reg_we && kind == K_CTRL) begin
      if (bsel) wake_en_d   = reg_wdata[0];
      else      idle_qual_d = reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_qual_q <= 1'b0;
      wake_en_q   <= 1'b0;
    end else begin
      idle_qual_q <= idle_qual_d;
      wake_en_q   <= wake_en_d;
    end
  end

  assign irq_o       = |irqp_a;
  assign fiq_o       = |fiqp_a;
  assign idle_wake_o = idle_qual_q ? |(pend_a & mask_a) : |pend_flat;
  assign sys_wake_o  = wake_en_q & pend_flat[RTC_SRC];

  always_comb begin
    reg_rdata = '0;
    case (kind)
      K_MASK:  reg_rdata = mask_a[bsel];
      K_STEER: reg_rdata = steer_a[bsel];
      K_RAW:   reg_rdata = pend_a[bsel];
      K_IRQP:  reg_rdata = irqp_a[bsel];
      K_FIQP:  reg_rdata = fiqp_a[bsel];
      K_CTRL:  reg_rdata[0] = bsel ? wake_en_q : idle_qual_q;
      default: reg_rdata = '0;
    endcase
  end

  // R3: the normal line needs an enabled, pending source
  a_r3_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(pend_a & mask_a)));
  // R4: the fast line needs some source steered to it
  a_r4_fiq_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (|steer_a));
  // R6: in qualified mode, idle exit needs an enabled source
  a_r6_qualified_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_qual_q && idle_wake_o) |-> (|mask_a));
  // R7: alarm wake needs the alarm source pending
  a_r7_alarm_wake: assert property (@(posedge clk) disable iff (!rst_n)
    sys_wake_o |-> pend_flat[RTC_SRC]);
endmodule

// File: tb/dual_bank_intc_bench.sv
`timescale 1ns/1ps
module dual_bank_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, fiq, iwake, swake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_mask, m_steer;
  logic        m_qual, m_wen;

  always #2 clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .fiq_o(fiq),
    .idle_wake_o(iwake), .sys_wake_o(swake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic set_src(input logic [63:0] s);
    @(negedge clk);
    src = s;
    repeat (2) @(negedge clk);
  endtask

  // Compare every output and status register against the bench model
  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [63:0] ip, fp;
    ip = src & m_mask & ~m_steer;
    fp = src & m_mask & m_steer;
    check({tag, " R3 irq"}, {31'd0, irq}, {31'd0, |ip});
    check({tag, " R4 fiq"}, {31'd0, fiq}, {31'd0, |fp});
    check({tag, " R6 idle"}, {31'd0, iwake},
          {31'd0, m_qual ? |(src & m_mask) : |src});
    check({tag, " R7 alarm"}, {31'd0, swake}, {31'd0, m_wen & src[63]});
    rd(4'h4, d); check({tag, " R2 raw0"}, d, src[31:0]);
    rd(4'h5, d); check({tag, " R2 raw1"}, d, src[63:32]);
    rd(4'h6, d); check({tag, " R5 irqp0"}, d, ip[31:0]);
    rd(4'h7, d); check({tag, " R5 irqp1"}, d, ip[63:32]);
    rd(4'h8, d); check({tag, " R5 fiqp0"}, d, fp[31:0]);
    rd(4'h9, d); check({tag, " R5 fiqp1"}, d, fp[63:32]);
    rd(4'h0, d); check({tag, " R9 mask0"}, d, m_mask[31:0]);
    rd(4'h1, d); check({tag, " R9 mask1"}, d, m_mask[63:32]);
    rd(4'h2, d); check({tag, " R9 steer0"}, d, m_steer[31:0]);
    rd(4'h3, d); check({tag, " R9 steer1"}, d, m_steer[63:32]);
  endtask

  function automatic logic [63:0] step(input logic [63:0] x);
    return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] lf;
    rst_n = 1'b0; src = '0; we = 1'b0; addr = '0; wdata = '0;
    m_mask = '0; m_steer = '0; m_qual = 1'b0; m_wen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, all sources high
    set_src({64{1'b1}});
    rd(4'h0, d); check("R1 mask0", d, 32'd0);
    rd(4'h3, d); check("R1 steer1", d, 32'd0);
    rd(4'hA, d); check("R1 qual", d, 32'd0);
    rd(4'hB, d); check("R1 wen", d, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 fiq", {31'd0, fiq}, 32'd0);
    check("R1 alarm", {31'd0, swake}, 32'd0);
    check_all("R1 all");

    // R2: two-edge latency, rise and fall
    @(negedge clk); src = 64'h0000_0001_8000_0000;
    @(negedge clk); rd(4'h4, d); check("R2 one edge", d, 32'hFFFF_FFFF);
    @(negedge clk); rd(4'h4, d); check("R2 two edges", d, 32'h8000_0000);
    rd(4'h5, d); check("R2 two edges b1", d, 32'h0000_0001);
    @(negedge clk); src = '0;
    @(negedge clk); rd(4'h5, d); check("R2 fall one edge", d, 32'h1);
    @(negedge clk); rd(4'h5, d); check("R2 fall two edges", d, 32'h0);

    // R8: control stores bit 0 only; read-only and unmapped writes ignored
    wr(4'hA, 32'hFFFF_FFFF); m_qual = 1'b1;
    rd(4'hA, d); check("R8 qual bit0", d, 32'h1);
    wr(4'hB, 32'hFFFF_FFFE);
    rd(4'hB, d); check("R8 wen bit0", d, 32'h0);
    wr(4'h4, 32'h1234_5678); wr(4'hC, 32'hFFFF_FFFF); wr(4'hF, 32'hFFFF_FFFF);
    for (int a = 12; a < 16; a++) begin
      rd(a[3:0], d); check("R8 unmapped", d, 32'h0);
    end
    check_all("R8 after ro writes");

    // R3/R4/R6 one-hot sweep over all 64 sources, alternating steering
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h2, 32'hAAAA_AAAA); wr(4'h3, 32'h5555_5555);
    m_mask = '1; m_steer = 64'h5555_5555_AAAA_AAAA;
    for (int i = 0; i < 64; i++) begin
      set_src(64'd1 << i);
      check("R3 sweep irq", {31'd0, irq}, {31'd0, ~m_steer[i]});
      check("R4 sweep fiq", {31'd0, fiq}, {31'd0, m_steer[i]});
      check("R6 sweep idle", {31'd0, iwake}, 32'd1);
    end

    // R7: alarm wake ignores mask and steering
    wr(4'h1, 32'h0); m_mask[63:32] = '0;
    wr(4'hB, 32'h1); m_wen = 1'b1;
    set_src(64'h8000_0000_0000_0000);
    check("R7 alarm masked", {31'd0, swake}, 32'd1);
    check("R6 masked no idle", {31'd0, iwake}, 32'd0);
    wr(4'hA, 32'h0); m_qual = 1'b0;
    check("R6 unqualified idle", {31'd0, iwake}, 32'd1);

    // Pseudo-random patterns over mask, steering, sources and control
    lf = 64'h9E37_79B9_7F4A_7C15;
    for (int n = 0; n < 60; n++) begin
      lf = step(lf); wr(4'h0, lf[31:0]);  m_mask[31:0]   = lf[31:0];
      lf = step(lf); wr(4'h1, lf[63:32]); m_mask[63:32]  = lf[63:32];
      lf = step(lf); wr(4'h2, lf[31:0]);  m_steer[31:0]  = lf[31:0];
      lf = step(lf); wr(4'h3, lf[63:32]); m_steer[63:32] = lf[63:32];
      wr(4'hA, {31'd0, lf[5]}); m_qual = lf[5];
      wr(4'hB, {31'd0, lf[9]}); m_wen  = lf[9];
      lf = step(lf);
      set_src((n % 3 == 0) ? (lf & step(lf) & step(step(lf))) : lf);
      check_all("R3 R5 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule